// File: doc/BRIEF.md
# Calibrated RTC Seconds Counter

This block is the timekeeping core of a real-time clock that runs on a slow crystal clock of about 33.33 kHz. A tick counter divides the crystal clock down to one-second events. It counts from zero up to a programmable maximum, and one extra tick can be added to some seconds of every 16-second cycle. This trims the long-term drift that a whole-number divider leaves behind. Each second event increments a 32-bit seconds count and produces a one-cycle pulse.

Software programs the block through a plain register port. A write is taken in the cycle where `wr_en` is high, and read data is combinational from `addr`. A new time goes into a set-time register. That write restarts the tick counter, and the value becomes the current time only at the end of the freshly started full second. Writing the calibration word also restarts the second and resets the drift-correction phase, so the next second event lands exactly one full second after the write. The control word stores an oscillator-enable bit, which gates all counting, and a battery-switch enable bit, which is only held for use elsewhere.

Top module: `rtc_sec_core`

## Requirements
- R1: After reset, the calibration readback (0x0C) returns 0x198233, control (0x40) returns 0x01000000 (oscillator on, battery switch off), the set-time readback (0x04), current time (0x10) and current tick (0x14) return 0, and `sec_pulse` is low.
- R2: The calibration word written at 0x08 is 21 bits wide. Bits [15:0] hold the tick maximum, bits [19:16] the correction count N, and bit 20 the correction enable. The readback at 0x0C returns those 21 bits, with bits [31:21] reading 0.
- R3: A write to 0x08 sets the tick count to 0 and resets the 16-second correction phase. The next second event comes after exactly L+1 clock cycles, where L is the tick maximum plus any extra tick. If the write lands in the cycle where a second would end, that second is cancelled.
- R4: The set-time readback (0x04) returns the last value written to 0x00. A write to 0x00 sets the tick count to 0. The current time keeps its old value until the next second event, and then takes the written value.
- R5: When the tick count equals its limit, it returns to 0 on the next edge. At that same edge the current time increments (or loads a pending set value) and `sec_pulse` is high for one cycle. Without correction, one second lasts tick maximum + 1 cycles.
- R6: When correction is enabled, the first N seconds of each 16-second phase cycle each last one extra clock cycle. The other seconds of the cycle keep the normal length.
- R7: When correction enable (bit 20) is clear, every second lasts tick maximum + 1 cycles, whatever N holds.
- R8: Control bits 24 (oscillator enable) and 31 (battery-switch enable) can be written and read back, and all other control bits read 0. While bit 24 is clear, the tick count and current time stay frozen and no pulse is produced.
- R9: The current time wraps from 0xFFFFFFFF to 0 at a second event.
- R10: The current-tick register (0x14) returns the live tick count. Writes to 0x04, 0x0C, 0x10 and 0x14 have no effect. An unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock, about 33.33 kHz |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 8 | Register byte address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| sec_pulse | output | 1 | One-cycle pulse at each second event |

## Verification
The bench builds the block with its default parameters: a 16-bit tick maximum, a 4-bit correction count, correction logic included and the 0x198233 reset word. One second is timed at the reset calibration, which takes 33333 cycles including the extra correction tick. The bench then reprograms the tick maximum to 3. With seconds that short, a full 16-second correction cycle, the wrap of the seconds count from a loaded 0xFFFFFFFF, cancelled and restarted seconds, and an oscillator pause all fit within a short run.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
   localparam int REG_AW = 8;
   localparam logic [REG_AW-1:0] A_SET_WR  = 8'h00;
   localparam logic [REG_AW-1:0] A_SET_RD  = 8'h04;
   localparam logic [REG_AW-1:0] A_CAL_WR  = 8'h08;
   localparam logic [REG_AW-1:0] A_CAL_RD  = 8'h0C;
   localparam logic [REG_AW-1:0] A_NOW     = 8'h10;
   localparam logic [REG_AW-1:0] A_TICK    = 8'h14;
   localparam logic [REG_AW-1:0] A_CTRL    = 8'h40;
   localparam int CTRL_OSC_BIT = 24;
   localparam int CTRL_BAT_BIT = 31;

   typedef struct packed {
      logic bat_en;
      logic osc_en;
   } ctrl_t;
endpackage

// File: rtl/rtc_tick_divider.sv
module rtc_tick_divider #(
   parameter int TICK_W   = 16,
   parameter int FRAC_W   = 4,
   parameter bit HAS_FRAC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_en,
   input  logic              restart,
   input  logic              phase_clr,
   input  logic [TICK_W-1:0] tmax,
   input  logic [FRAC_W-1:0] frac_val,
   input  logic              frac_en,
   output logic [TICK_W-1:0] tick_cnt,
   output logic              sec_evt
);
   localparam int CNT_W = TICK_W + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;
   logic             extra;

   generate
      if (HAS_FRAC) begin : g_frac
         logic [FRAC_W-1:0] phase_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               phase_q <= '0;
            else if (phase_clr)
               phase_q <= '0;
            else if (sec_evt)
               phase_q <= phase_q + 1'b1;
         end

         assign extra = frac_en && (phase_q < frac_val);

         p_phase_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (sec_evt && !phase_clr) |=> (phase_q == FRAC_W'($past(phase_q) + 1'b1)));
      end else begin : g_nofrac
         assign extra = 1'b0;
      end
   endgenerate

   assign limit    = {1'b0, tmax} + CNT_W'(extra);
   assign sec_evt  = osc_en && !restart && (cnt_q == limit);
   assign tick_cnt = cnt_q[TICK_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (restart)
         cnt_q <= '0;
      else if (osc_en) begin
         if (cnt_q == limit)
            cnt_q <= '0;
         else
            cnt_q <= cnt_q + 1'b1;
      end
   end

   p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= limit);

   p_restart_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt_q == '0));

   p_osc_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc_en && !restart) |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
   parameter int SEC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sec_evt,
   input  logic             set_wr,
   input  logic [SEC_W-1:0] set_val,
   output logic [SEC_W-1:0] secs,
   output logic             sec_pulse
);
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q    <= 1'b0;
         secs      <= '0;
         sec_pulse <= 1'b0;
      end else begin
         sec_pulse <= sec_evt;
         if (set_wr)
            pend_q <= 1'b1;
         else if (sec_evt)
            pend_q <= 1'b0;
         if (sec_evt)
            secs <= pend_q ? set_val : secs + 1'b1;
      end
   end

   p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_evt && !pend_q) |=> (secs == SEC_W'($past(secs) + 1'b1)));

   p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_evt && pend_q) |=> (secs == $past(set_val)));

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !sec_evt |=> $stable(secs));

   p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sec_evt |=> sec_pulse);
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
   import rtc_cal_pkg::*;
#(
   parameter int          ADDR_W    = 8,
   parameter int          DATA_W    = 32,
   parameter int          SEC_W     = 32,
   parameter int          TICK_W    = 16,
   parameter int          CAL_W     = 21,
   parameter logic [31:0] CAL_RESET = 32'h0019_8233
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [TICK_W-1:0] tick_cnt,
   input  logic [SEC_W-1:0]  secs,
   output logic [DATA_W-1:0] rdata,
   output logic [CAL_W-1:0]  cal_q,
   output ctrl_t             ctrl_q,
   output logic [SEC_W-1:0]  set_val,
   output logic              cal_wr,
   output logic              set_wr
);
   assign set_wr = wr_en && (addr == ADDR_W'(A_SET_WR));
   assign cal_wr = wr_en && (addr == ADDR_W'(A_CAL_WR));

   logic ctrl_wr;
   assign ctrl_wr = wr_en && (addr == ADDR_W'(A_CTRL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cal_q         <= CAL_RESET[CAL_W-1:0];
         set_val       <= '0;
         ctrl_q.osc_en <= 1'b1;
         ctrl_q.bat_en <= 1'b0;
      end else begin
         if (cal_wr)
            cal_q <= wdata[CAL_W-1:0];
         if (set_wr)
            set_val <= wdata[SEC_W-1:0];
         if (ctrl_wr) begin
            ctrl_q.osc_en <= wdata[CTRL_OSC_BIT];
            ctrl_q.bat_en <= wdata[CTRL_BAT_BIT];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(A_SET_RD))
         rdata = DATA_W'(set_val);
      else if (addr == ADDR_W'(A_CAL_RD))
         rdata = DATA_W'(cal_q);
      else if (addr == ADDR_W'(A_NOW))
         rdata = DATA_W'(secs);
      else if (addr == ADDR_W'(A_TICK))
         rdata = DATA_W'(tick_cnt);
      else if (addr == ADDR_W'(A_CTRL)) begin
         rdata[CTRL_OSC_BIT] = ctrl_q.osc_en;
         rdata[CTRL_BAT_BIT] = ctrl_q.bat_en;
      end
   end

   p_cal_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cal_wr |=> $stable(cal_q));

   p_set_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !set_wr |=> $stable(set_val));
endmodule

// File: rtl/rtc_sec_core.sv
module rtc_sec_core
   import rtc_cal_pkg::*;
#(
   parameter int          ADDR_W    = 8,
   parameter int          DATA_W    = 32,
   parameter int          SEC_W     = 32,
   parameter int          TICK_W    = 16,
   parameter int          FRAC_W    = 4,
   parameter bit          HAS_FRAC  = 1'b1,
   parameter logic [31:0] CAL_RESET = 32'h0019_8233
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              sec_pulse
);
   localparam int CAL_W   = TICK_W + FRAC_W + 1;
   localparam int FRAC_LO = TICK_W;
   localparam int EN_BIT  = TICK_W + FRAC_W;

   generate
      if (TICK_W < 2 || TICK_W > 24) begin : g_bad_tick
         $error("rtc_sec_core: TICK_W out of range");
      end
      if (FRAC_W < 1 || FRAC_W > 6) begin : g_bad_frac
         $error("rtc_sec_core: FRAC_W out of range");
      end
      if (SEC_W < 8 || SEC_W > DATA_W) begin : g_bad_sec
         $error("rtc_sec_core: SEC_W must lie between 8 and DATA_W");
      end
      if (CAL_W > DATA_W) begin : g_bad_cal
         $error("rtc_sec_core: calibration word wider than data bus");
      end
      if (ADDR_W < REG_AW) begin : g_bad_addr
         $error("rtc_sec_core: ADDR_W too narrow for register map");
      end
      if ((CAL_RESET >> CAL_W) != 32'd0) begin : g_bad_rst
         $error("rtc_sec_core: CAL_RESET wider than calibration word");
      end
   endgenerate

   logic [CAL_W-1:0]  cal_q;
   ctrl_t             ctrl_q;
   logic [SEC_W-1:0]  set_val;
   logic [SEC_W-1:0]  secs;
   logic [TICK_W-1:0] tick_cnt;
   logic              cal_wr;
   logic              set_wr;
   logic              sec_evt;
   logic              restart;

   assign restart = cal_wr || set_wr;

   rtc_regs #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .SEC_W    (SEC_W),
      .TICK_W   (TICK_W),
      .CAL_W    (CAL_W),
      .CAL_RESET(CAL_RESET)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .tick_cnt(tick_cnt),
      .secs    (secs),
      .rdata   (rdata),
      .cal_q   (cal_q),
      .ctrl_q  (ctrl_q),
      .set_val (set_val),
      .cal_wr  (cal_wr),
      .set_wr  (set_wr)
   );

   rtc_tick_divider #(
      .TICK_W  (TICK_W),
      .FRAC_W  (FRAC_W),
      .HAS_FRAC(HAS_FRAC)
   ) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .osc_en   (ctrl_q.osc_en),
      .restart  (restart),
      .phase_clr(cal_wr),
      .tmax     (cal_q[TICK_W-1:0]),
      .frac_val (cal_q[FRAC_LO +: FRAC_W]),
      .frac_en  (cal_q[EN_BIT]),
      .tick_cnt (tick_cnt),
      .sec_evt  (sec_evt)
   );

   rtc_seconds #(
      .SEC_W(SEC_W)
   ) u_secs (
      .clk      (clk),
      .rst_n    (rst_n),
      .sec_evt  (sec_evt),
      .set_wr   (set_wr),
      .set_val  (set_val),
      .secs     (secs),
      .sec_pulse(sec_pulse)
   );

   p_no_evt_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !sec_pulse);

   p_frozen_time_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q.osc_en |=> !sec_pulse);
endmodule

// File: tb/test_rtc_sec_core.sv
`timescale 1ns/1ps
module test_rtc_sec_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        sec_pulse;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   rtc_sec_core i_rtc_sec_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .addr     (addr),
      .wdata    (wdata),
      .rdata    (rdata),
      .sec_pulse(sec_pulse)
   );

   // {write address, write data, read address, expected read}
   localparam int NV = 10;
   localparam logic [79:0] VEC [NV] = '{
      {8'h00, 32'hDEADBEEF, 8'h04, 32'hDEADBEEF},
      {8'h08, 32'hFFFFFFFF, 8'h0C, 32'h001FFFFF},
      {8'h40, 32'hFFFFFFFF, 8'h40, 32'h81000000},
      {8'h40, 32'h00000000, 8'h40, 32'h00000000},
      {8'h08, 32'h00012345, 8'h0C, 32'h00012345},
      {8'h04, 32'h12345678, 8'h04, 32'hDEADBEEF},
      {8'h10, 32'h55555555, 8'h10, 32'h00000000},
      {8'h14, 32'h0000FFFF, 8'h14, 32'h00000000},
      {8'h0C, 32'hAAAAAAAA, 8'h0C, 32'h00012345},
      {8'h3C, 32'hFFFFFFFF, 8'h3C, 32'h00000000}
   };

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 190000) begin
         n_bad = n_bad + 1;
         $display("FAIL watchdog expired actual=%0d expected<190000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk = n_chk + 1;
      if (act !== exp) begin
         n_bad = n_bad + 1;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      addr  = a;
      wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      addr = a;
      #1;
      v = rdata;
   endtask

   task automatic wait_pulse(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!sec_pulse && n < 100000);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      logic [31:0] v;
      logic [31:0] t0;
      logic [31:0] k0;
      int n;
      bit seen;

      do_reset();
      // R1 reset state
      rd(8'h0C, v); chk("R1 cal reset", v, 32'h00198233);
      rd(8'h40, v); chk("R1 ctrl reset", v, 32'h01000000);
      rd(8'h04, v); chk("R1 set readback reset", v, 32'h0);
      rd(8'h10, v); chk("R1 time reset", v, 32'h0);
      rd(8'h14, v); chk("R1 tick reset", v, 32'h0);
      chk("R1 pulse low", {31'b0, sec_pulse}, 32'h0);

      // register table: R2 R4 R8 R10
      for (int i = 0; i < NV; i++) begin
         wr(VEC[i][79:72], VEC[i][71:40]);
         rd(VEC[i][39:32], v);
         chk($sformatf("R2/R4/R8/R10 table vector %0d", i), v, VEC[i][31:0]);
      end

      do_reset();
      // R6 default calibration: tick max 0x8233 + one extra tick
      wr(8'h08, 32'h00198233);
      wait_pulse(n);
      chk("R6 default second length", n, 33333);
      @(negedge clk);
      chk("R5 pulse one cycle", {31'b0, sec_pulse}, 32'h0);
      rd(8'h10, v); chk("R5 time after first second", v, 32'h1);

      // R6 fractional correction, tick max 3, N = 2
      wr(8'h08, 32'h00120003);
      for (int s = 0; s < 18; s++) begin
         wait_pulse(n);
         chk($sformatf("R6 second %0d length", s), n, ((s % 16) < 2) ? 5 : 4);
      end
      rd(8'h10, v); chk("R5 time after 19 seconds", v, 32'd19);

      // R7 correction disabled, N still 2
      wr(8'h08, 32'h00020003);
      for (int s = 0; s < 4; s++) begin
         wait_pulse(n);
         chk("R7 uncorrected second", n, 4);
      end

      // R10 live tick, R3 restart and cancelled second
      wr(8'h08, 32'h00000003);
      rd(8'h14, v); chk("R10 tick after cal write", v, 32'h0);
      @(negedge clk); @(negedge clk);
      rd(8'h14, v); chk("R10 tick live", v, 32'h2);
      wr(8'h08, 32'h00000003);
      chk("R3 second cancelled by write", {31'b0, sec_pulse}, 32'h0);
      wait_pulse(n);
      chk("R3 full second after cal write", n, 4);

      // R4 set-time load at next second
      @(negedge clk); @(negedge clk);
      rd(8'h10, t0);
      wr(8'h00, 32'h00000100);
      rd(8'h10, v); chk("R4 time unchanged before second", v, t0);
      rd(8'h04, v); chk("R4 set readback", v, 32'h00000100);
      wait_pulse(n);
      chk("R4 full second after set write", n, 4);
      rd(8'h10, v); chk("R4 loaded time", v, 32'h00000100);
      wait_pulse(n);
      rd(8'h10, v); chk("R5 increment after load", v, 32'h00000101);

      // R9 wrap
      wr(8'h00, 32'hFFFFFFFF);
      wait_pulse(n);
      rd(8'h10, v); chk("R9 loaded max", v, 32'hFFFFFFFF);
      wait_pulse(n);
      rd(8'h10, v); chk("R9 wrap to zero", v, 32'h0);

      // R8 oscillator gate
      @(negedge clk);
      wr(8'h40, 32'h80000000);
      rd(8'h40, v); chk("R8 ctrl battery only", v, 32'h80000000);
      rd(8'h14, k0);
      rd(8'h10, t0);
      seen = 1'b0;
      for (int c = 0; c < 20; c++) begin
         @(negedge clk);
         if (sec_pulse) seen = 1'b1;
      end
      chk("R8 no pulse while stopped", {31'b0, seen}, 32'h0);
      rd(8'h14, v); chk("R8 tick frozen", v, k0);
      rd(8'h10, v); chk("R8 time frozen", v, t0);
      wr(8'h40, 32'h01000000);
      wait_pulse(n);
      chk("R8 resumes from frozen tick", n, 4 - int'(k0));
      rd(8'h10, v); chk("R8 time resumes", v, t0 + 32'd1);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule